// File: doc/BRIEF.md
# Virtual Page Translation Cache

This block is a small set-associative store of address translations. Each entry is keyed by a virtual page number (VPN) and holds exactly one page table entry (PTE), so there are no byte-offset bits. A core presents a VPN on the lookup port. One clock later the block reports hit or miss and, on a hit, the stored PTE. After a miss, an external page walker fetches the PTE and writes it back through the fill port under the same VPN.

Nothing in the block watches page-table memory. Software keeps the cache coherent with two explicit commands: drop the entry for one VPN, or drop every entry. Within a set, a fill goes first to a way that already holds the VPN, then to the lowest-numbered empty way, and only then to the way chosen by a pseudo-LRU tree.

Control is a three-state response machine: RSP_IDLE, RSP_HIT and RSP_MISS. In every state a lookup request moves the machine to RSP_HIT if the VPN matches a valid way, or to RSP_MISS if it does not. With no request the machine goes to RSP_IDLE. Each cycle the maintenance decoder picks exactly one action from MNT_NONE, MNT_FILL, MNT_INV_ONE and MNT_INV_ALL.

Top module: `xlat_cache`

## Requirements
- R1: After reset every way is empty and rsp_valid is low, so the first lookup of any VPN misses.
- R2: rsp_valid is high in exactly the cycle after a cycle with lk_valid high. rsp_hit and rsp_pte reflect the contents as they stood before any fill or invalidate issued in the same cycle as the lookup.
- R3: The low log2(SETS) bits of a VPN select the set and the remaining upper bits form the tag. VPNs that share low bits but differ in upper bits are separate entries, and a set holds up to WAYS of them.
- R4: After a fill of VPN v with PTE p, a lookup of v hits and returns p. A miss returns rsp_pte equal to zero.
- R5: A fill whose VPN is already present overwrites that way in place. A later lookup returns the newest PTE, and no other entry of the set is displaced.
- R6: A fill of an absent VPN uses the lowest-numbered empty way of its set before it evicts any valid way.
- R7: With every way of a set valid, the victim comes from a tree of WAYS-1 bits per set. Node 0 is the root, and node n has children 2n+1 (lower half) and 2n+2 (upper half). A node bit of 1 points the victim toward the upper half. A lookup hit, or a fill into a way, flips every node on that way's path to point away from it. A same-cycle lookup touch is applied before the fill touch.
- R8: A single-VPN invalidate removes only the matching entry. An invalidate for an absent VPN changes nothing.
- R9: An invalidate-all empties every way in one cycle, so a lookup issued the next cycle misses.
- R10: When either invalidate is asserted in the same cycle as a fill, the fill is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | VPN to look up |
| fill_valid | input | 1 | Install request from the walker |
| fill_vpn | input | VPN_W | VPN the fill is filed under |
| fill_pte | input | PTE_W | PTE to store |
| inv_one | input | 1 | Invalidate the entry for inv_vpn |
| inv_vpn | input | VPN_W | VPN to invalidate |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup matched a valid entry |
| rsp_pte | output | PTE_W | PTE on hit, zero on miss |

## Verification
The bench targets several corner cases. A lookup and a fill of the same VPN in one cycle must miss; a design that forwarded the fill would hit. A refill of a present VPN must not waste a way; a design that duplicated it would later lose a neighbour in the set. A fill into a set with one hole must fill the hole rather than evict the PLRU victim; getting this wrong drops a live entry. A fill that collides with either invalidate must be discarded; a design that kept it would hit afterwards. A long pseudo-random run over a few sets, checked against an arithmetic PLRU model, exposes any wrong tree bit as a wrong hit or miss.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;

    typedef enum logic [1:0] {
        MNT_NONE    = 2'd0,
        MNT_FILL    = 2'd1,
        MNT_INV_ONE = 2'd2,
        MNT_INV_ALL = 2'd3
    } mnt_op_e;

    // Invalidates outrank fills; invalidate-all outranks single invalidate.
    function automatic mnt_op_e mnt_decode(input logic fill, input logic inv1, input logic inva);
        if (inva)      return MNT_INV_ALL;
        else if (inv1) return MNT_INV_ONE;
        else if (fill) return MNT_FILL;
        else           return MNT_NONE;
    endfunction

endpackage

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
module xlat_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            row_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
    input  logic [TAG_W-1:0]           key_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);

    logic [WAYS-1:0] hit_vec;

    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_cmp
            assign hit_vec[w] = row_valid[w] && (row_tag[w] == key_tag);
        end
    endgenerate

    assign hit = |hit_vec;

    // At most one way matches, since fills never duplicate a VPN.
    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) hit_way = WAY_W'(i);
        end
    end

endmodule

// File: rtl/xlat_plru.sv
`timescale 1ns/1ps
module xlat_plru #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_en,
    input  logic [IDX_W-1:0] a_set,
    input  logic [WAY_W-1:0] a_way,
    input  logic             b_en,
    input  logic [IDX_W-1:0] b_set,
    input  logic [WAY_W-1:0] b_way,
    input  logic [IDX_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim
);

    localparam int NODES = WAYS - 1;

    logic [NODES-1:0] tree_q [SETS];
    logic [NODES-1:0] tree_d [SETS];

    function automatic logic [NODES-1:0] tree_touch(input logic [NODES-1:0] t,
                                                    input logic [WAY_W-1:0] way);
        logic [NODES-1:0] r;
        int n;
        r = t;
        n = 0;
        for (int l = 0; l < WAY_W; l++) begin
            logic b;
            b = way[WAY_W-1-l];
            r[WAY_W'(n)] = ~b;
            n = 2 * n + 1 + int'(b);
        end
        return r;
    endfunction

    function automatic logic [WAY_W-1:0] tree_pick(input logic [NODES-1:0] t);
        logic [WAY_W-1:0] v;
        int n;
        v = '0;
        n = 0;
        for (int l = 0; l < WAY_W; l++) begin
            logic b;
            b = t[WAY_W'(n)];
            v[WAY_W-1-l] = b;
            n = 2 * n + 1 + int'(b);
        end
        return v;
    endfunction

    genvar s;
    generate
        for (s = 0; s < SETS; s++) begin : g_set
            always_comb begin
                logic [NODES-1:0] t1;
                t1 = tree_q[s];
                if (a_en && (a_set == IDX_W'(s))) t1 = tree_touch(t1, a_way);
                if (b_en && (b_set == IDX_W'(s))) t1 = tree_touch(t1, b_way);
                tree_d[s] = t1;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) tree_q[i] <= '0;
        end else begin
            for (int i = 0; i < SETS; i++) tree_q[i] <= tree_d[i];
        end
    end

    assign victim = tree_pick(tree_q[rd_set]);

endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PTE_W = 32,
    parameter int SETS  = 16,
    parameter int WAYS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PTE_W-1:0] fill_pte,
    input  logic             inv_one,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             inv_all,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PTE_W-1:0] rsp_pte
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    // Entry storage: one PTE per way, no byte offset.
    logic [SETS-1:0][WAYS-1:0]            valid_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
    logic [SETS-1:0][WAYS-1:0][PTE_W-1:0] pte_q;

    // VPN split: low bits pick the set, the rest is the tag.
    logic [IDX_W-1:0] lk_set, fl_set, iv_set;
    logic [TAG_W-1:0] lk_tag, fl_tag, iv_tag;

    assign lk_set = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
    assign fl_set = fill_vpn[IDX_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1:IDX_W];
    assign iv_set = inv_vpn[IDX_W-1:0];
    assign iv_tag = inv_vpn[VPN_W-1:IDX_W];

    logic             lk_hit, fl_hit, iv_hit;
    logic [WAY_W-1:0] lk_way, fl_way, iv_way;

    xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .row_valid (valid_q[lk_set]),
        .row_tag   (tag_q[lk_set]),
        .key_tag   (lk_tag),
        .hit       (lk_hit),
        .hit_way   (lk_way)
    );

    xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
        .row_valid (valid_q[fl_set]),
        .row_tag   (tag_q[fl_set]),
        .key_tag   (fl_tag),
        .hit       (fl_hit),
        .hit_way   (fl_way)
    );

    xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_iv_match (
        .row_valid (valid_q[iv_set]),
        .row_tag   (tag_q[iv_set]),
        .key_tag   (iv_tag),
        .hit       (iv_hit),
        .hit_way   (iv_way)
    );

    // Maintenance action for this cycle.
    mnt_op_e mnt_op;
    assign mnt_op = mnt_decode(fill_valid, inv_one, inv_all);

    // Lowest-numbered empty way in the fill set.
    logic             fl_has_free;
    logic [WAY_W-1:0] fl_free_way;

    always_comb begin
        fl_has_free = 1'b0;
        fl_free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_q[fl_set][w]) begin
                fl_has_free = 1'b1;
                fl_free_way = WAY_W'(w);
            end
        end
    end

    logic [WAY_W-1:0] fl_victim;
    logic [WAY_W-1:0] fl_target;

    xlat_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_en   (lk_valid && lk_hit),
        .a_set  (lk_set),
        .a_way  (lk_way),
        .b_en   (mnt_op == MNT_FILL),
        .b_set  (fl_set),
        .b_way  (fl_target),
        .rd_set (fl_set),
        .victim (fl_victim)
    );

    // Same VPN first, then an empty way, then the tree victim.
    always_comb begin
        if (fl_hit)           fl_target = fl_way;
        else if (fl_has_free) fl_target = fl_free_way;
        else                  fl_target = fl_victim;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            unique case (mnt_op)
                MNT_INV_ALL: valid_q <= '0;
                MNT_INV_ONE: if (iv_hit) valid_q[iv_set][iv_way] <= 1'b0;
                MNT_FILL:    valid_q[fl_set][fl_target] <= 1'b1;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (mnt_op == MNT_FILL) begin
            tag_q[fl_set][fl_target] <= fl_tag;
            pte_q[fl_set][fl_target] <= fill_pte;
        end
    end

    // Response state machine.
    rsp_state_e       rsp_q, rsp_d;
    logic [PTE_W-1:0] rsp_pte_q;

    always_comb begin
        unique case (rsp_q)
            RSP_IDLE, RSP_HIT, RSP_MISS:
                rsp_d = !lk_valid ? RSP_IDLE : (lk_hit ? RSP_HIT : RSP_MISS);
            default:
                rsp_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= RSP_IDLE;
        else        rsp_q <= rsp_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  rsp_pte_q <= '0;
        else if (lk_valid && lk_hit) rsp_pte_q <= pte_q[lk_set][lk_way];
        else                         rsp_pte_q <= '0;
    end

    always_comb begin
        unique case (rsp_q)
            RSP_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
            end
            RSP_MISS: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b0;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_hit   = 1'b0;
            end
        endcase
    end

    assign rsp_pte = rsp_pte_q;

endmodule

// File: rtl/xlat_cache_chk.sv
`timescale 1ns/1ps
module xlat_cache_chk #(
    parameter int VPN_W = 20,
    parameter int PTE_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             fill_valid,
    input logic [VPN_W-1:0] fill_vpn,
    input logic [PTE_W-1:0] fill_pte,
    input logic             inv_one,
    input logic [VPN_W-1:0] inv_vpn,
    input logic             inv_all,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [PTE_W-1:0] rsp_pte
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R4
    miss_pte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_pte == '0));

    // R4
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !inv_one && !inv_all) ##1 (lk_valid && lk_vpn == $past(fill_vpn))
        |=> (rsp_hit && rsp_pte == $past(fill_pte, 2)));

    // R8
    inv_one_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_one ##1 (lk_valid && lk_vpn == $past(inv_vpn))
        |=> (rsp_valid && !rsp_hit));

    // R9
    inv_all_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all ##1 lk_valid |=> (rsp_valid && !rsp_hit));

endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PTE_W(PTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_vpn     (lk_vpn),
    .fill_valid (fill_valid),
    .fill_vpn   (fill_vpn),
    .fill_pte   (fill_pte),
    .inv_one    (inv_one),
    .inv_vpn    (inv_vpn),
    .inv_all    (inv_all),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_pte    (rsp_pte)
);

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;

    localparam int VW  = 8;
    localparam int PW  = 12;
    localparam int NS  = 4;
    localparam int NWY = 4;
    localparam int IW  = 2;
    localparam int TW  = VW - IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic          fill_valid = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_pte = '0;
    logic          inv_one = 1'b0;
    logic [VW-1:0] inv_vpn = '0;
    logic          inv_all = 1'b0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [PW-1:0] rsp_pte;

    always #2.5 clk = ~clk;

    xlat_cache #(.VPN_W(VW), .PTE_W(PW), .SETS(NS), .WAYS(NWY)) u_xlat_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
        .inv_one(inv_one), .inv_vpn(inv_vpn), .inv_all(inv_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pte(rsp_pte)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    bit last_hit;
    logic [PW-1:0] last_pte;

    // Reference contents and replacement trees.
    bit            m_v   [NS][NWY];
    logic [TW-1:0] m_tag [NS][NWY];
    logic [PW-1:0] m_pte [NS][NWY];
    bit [2:0]      m_tree[NS];

    function automatic bit [2:0] m_touch(bit [2:0] t, int w);
        bit [2:0] r = t;
        r[0] = (w < 2);
        if (w < 2) r[1] = (w == 0);
        else       r[2] = (w == 2);
        return r;
    endfunction

    function automatic int m_pick(bit [2:0] t);
        if (t[0] == 1'b0) return t[1] ? 1 : 0;
        return t[2] ? 3 : 2;
    endfunction

    function automatic int m_find(logic [VW-1:0] vpn);
        int s = int'(vpn[IW-1:0]);
        for (int w = 0; w < NWY; w++)
            if (m_v[s][w] && m_tag[s][w] == vpn[VW-1:IW]) return w;
        return -1;
    endfunction

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // One operation cycle. Called at a falling edge; returns at the next one.
    task automatic step(string req, bit lv, logic [VW-1:0] lvpn,
                        bit fv, logic [VW-1:0] fvpn, logic [PW-1:0] fpte,
                        bit iov, logic [VW-1:0] ivpn, bit iav);
        int ls, lw, fs, fw, is, iw;
        bit eh;
        logic [PW-1:0] ep;
        ls = int'(lvpn[IW-1:0]);
        lw = m_find(lvpn);
        eh = lv && (lw >= 0);
        ep = eh ? m_pte[ls][lw] : '0;
        fs = int'(fvpn[IW-1:0]);
        fw = m_find(fvpn);
        if (fw < 0) begin
            for (int w = NWY - 1; w >= 0; w--) if (!m_v[fs][w]) fw = w;
        end
        if (fw < 0) fw = m_pick(m_tree[fs]);
        is = int'(ivpn[IW-1:0]);
        iw = m_find(ivpn);

        lk_valid = lv; lk_vpn = lvpn;
        fill_valid = fv; fill_vpn = fvpn; fill_pte = fpte;
        inv_one = iov; inv_vpn = ivpn; inv_all = iav;
        @(posedge clk);
        if (iav) begin
            for (int s = 0; s < NS; s++) for (int w = 0; w < NWY; w++) m_v[s][w] = 1'b0;
        end else if (iov) begin
            if (iw >= 0) m_v[is][iw] = 1'b0;
        end else if (fv) begin
            m_v[fs][fw] = 1'b1;
            m_tag[fs][fw] = fvpn[VW-1:IW];
            m_pte[fs][fw] = fpte;
        end
        if (eh) m_tree[ls] = m_touch(m_tree[ls], lw);
        if (fv && !iov && !iav) m_tree[fs] = m_touch(m_tree[fs], fw);
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0; inv_one = 1'b0; inv_all = 1'b0;
        check("R2", "rsp_valid", 32'(rsp_valid), 32'(lv));
        if (lv) begin
            check(req, "hit", 32'(rsp_hit), 32'(eh));
            check(eh ? req : "R4", "pte", 32'(rsp_pte), 32'(ep));
            last_hit = rsp_hit;
            last_pte = rsp_pte;
        end
    endtask

    task automatic look(string req, logic [VW-1:0] v);
        step(req, 1'b1, v, 1'b0, '0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic fill(string req, logic [VW-1:0] v, logic [PW-1:0] p);
        step(req, 1'b0, '0, 1'b1, v, p, 1'b0, '0, 1'b0);
    endtask

    task automatic inv1(string req, logic [VW-1:0] v);
        step(req, 1'b0, '0, 1'b0, '0, '0, 1'b1, v, 1'b0);
    endtask

    task automatic inva(string req);
        step(req, 1'b0, '0, 1'b0, '0, '0, 1'b0, '0, 1'b1);
    endtask

    task automatic expect_look(string req, logic [VW-1:0] v, bit h, logic [PW-1:0] p);
        look(req, v);
        check(req, "hit literal", 32'(last_hit), 32'(h));
        if (h) check(req, "pte literal", 32'(last_pte), 32'(p));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL R2 watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int s = 0; s < NS; s++) begin
            m_tree[s] = '0;
            for (int w = 0; w < NWY; w++) m_v[s][w] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset, first lookup misses
        check("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        expect_look("R1", 8'h00, 1'b0, '0);

        // R3: sixteen VPNs spread four per set, then sweep every VPN
        for (int k = 0; k < 16; k++) fill("R3", 8'(k), 12'(k * 37 + 5));
        for (int v = 0; v < 256; v++) expect_look("R3", 8'(v), v < 16, 12'(v * 37 + 5));

        // R2: lookup sees contents before a same-cycle fill
        inva("R9");
        step("R2", 1'b1, 8'h20, 1'b1, 8'h20, 12'h111, 1'b0, '0, 1'b0);
        check("R2", "same-cycle fill invisible", 32'(last_hit), 32'd0);
        expect_look("R4", 8'h20, 1'b1, 12'h111);

        // R5: refills of a present VPN overwrite in place
        inva("R9");
        fill("R5", 8'h01, 12'h101); fill("R5", 8'h05, 12'h105);
        fill("R5", 8'h09, 12'h109); fill("R5", 8'h0D, 12'h10D);
        fill("R5", 8'h05, 12'hABC); fill("R5", 8'h05, 12'hABD);
        expect_look("R5", 8'h01, 1'b1, 12'h101);
        expect_look("R5", 8'h05, 1'b1, 12'hABD);
        expect_look("R5", 8'h09, 1'b1, 12'h109);
        expect_look("R5", 8'h0D, 1'b1, 12'h10D);

        // R6: a hole is filled before any valid way is evicted
        inva("R9");
        fill("R6", 8'h01, 12'h201); fill("R6", 8'h05, 12'h205);
        fill("R6", 8'h09, 12'h209); fill("R6", 8'h0D, 12'h20D);
        inv1("R8", 8'h05);
        fill("R6", 8'h11, 12'h211);
        expect_look("R6", 8'h01, 1'b1, 12'h201);
        expect_look("R6", 8'h05, 1'b0, '0);
        expect_look("R6", 8'h09, 1'b1, 12'h209);
        expect_look("R6", 8'h0D, 1'b1, 12'h20D);
        expect_look("R6", 8'h11, 1'b1, 12'h211);

        // R7: after touching way 0, the tree picks way 2
        inva("R9");
        fill("R7", 8'h02, 12'h302); fill("R7", 8'h06, 12'h306);
        fill("R7", 8'h0A, 12'h30A); fill("R7", 8'h0E, 12'h30E);
        expect_look("R7", 8'h02, 1'b1, 12'h302);
        fill("R7", 8'h12, 12'h312);
        expect_look("R7", 8'h0A, 1'b0, '0);
        expect_look("R7", 8'h02, 1'b1, 12'h302);
        expect_look("R7", 8'h06, 1'b1, 12'h306);
        expect_look("R7", 8'h0E, 1'b1, 12'h30E);
        expect_look("R7", 8'h12, 1'b1, 12'h312);

        // R8: invalidate of absent VPN does nothing; present one is removed alone
        inva("R9");
        fill("R8", 8'h03, 12'h403); fill("R8", 8'h07, 12'h407);
        inv1("R8", 8'h0B);
        expect_look("R8", 8'h03, 1'b1, 12'h403);
        expect_look("R8", 8'h07, 1'b1, 12'h407);
        inv1("R8", 8'h07);
        expect_look("R8", 8'h07, 1'b0, '0);
        expect_look("R8", 8'h03, 1'b1, 12'h403);

        // R9: full flush in one cycle
        for (int k = 0; k < 16; k++) fill("R9", 8'(k + 16), 12'(k + 1));
        inva("R9");
        for (int k = 0; k < 16; k++) expect_look("R9", 8'(k + 16), 1'b0, '0);

        // R10: a fill alongside either invalidate is discarded
        step("R10", 1'b0, '0, 1'b1, 8'h04, 12'h504, 1'b1, 8'h08, 1'b0);
        expect_look("R10", 8'h04, 1'b0, '0);
        step("R10", 1'b0, '0, 1'b1, 8'h04, 12'h505, 1'b0, '0, 1'b1);
        expect_look("R10", 8'h04, 1'b0, '0);
        fill("R10", 8'h04, 12'h506);
        expect_look("R10", 8'h04, 1'b1, 12'h506);

        // R7: long mixed run against the reference tree model
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            logic [VW-1:0] v;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            v = {3'b000, lf[8:4]};
            case (lf[3:0])
                4'd8, 4'd9, 4'd10, 4'd11, 4'd12: fill("R7", v, lf[15:4] ^ 12'h5A5);
                4'd13: inv1("R8", v);
                4'd14: step("R7", 1'b1, v, 1'b1, {3'b000, lf[13:9]}, lf[11:0], 1'b0, '0, 1'b0);
                4'd15: if (lf[9:4] == 6'd0) inva("R9"); else look("R7", v);
                default: look("R7", v);
            endcase
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule